// File: doc/BRIEF.md
# Event Builder Round-Robin Selector

This block chooses which event-builder receiver takes each accepted event. A 16-bit enable mask names the receivers that take part. A 24-bit count sets how many events in a row one receiver takes before the selector moves on. The selector walks the enabled receivers in ascending index order and wraps from the highest enabled receiver back to the lowest.

The block also thins out the forwarding of headers and trailers. A separate 16-bit downscale factor sets how often this happens. The forward decision is returned as a flag and is also written into bit 14 of the trigger information word that goes out with the event.

Software writes the configuration through its own registers. It pulses a mask-write strobe whenever the mask changes, and the rotation then restarts at the lowest enabled receiver.

Top module: `evb_rr_selector`

## Requirements
- R1: Bit n of `cfg_rcv_mask` enables receiver n, and `out_rcv_idx` only ever names an enabled receiver. For example, mask 0x8103 gives only receivers 0, 1, 8 and 15.
- R2: Each receiver takes `cfg_evt_per_rcv` consecutive dispatched events before the selector advances to another receiver.
- R3: When the selector advances, it goes to the next higher enabled index, and from the highest enabled index it wraps to the lowest enabled index.
- R4: An events-per-receiver value of 0 behaves as 1.
- R5: A pulse on `cfg_mask_wr` clears the event count and restarts the rotation at the lowest enabled receiver. An event in the same cycle is already dispatched under the restarted rotation.
- R6: After reset, the first dispatched event goes to the lowest enabled receiver.
- R7: While the mask is all zero, an accepted event produces no valid output and advances neither the rotation nor the header counter.
- R8: A header factor of 0 sets the forward flag for every event.
- R9: For a header factor F > 0, number the dispatched events since reset from 0. Event k has its forward flag set exactly when k mod F = 0.
- R10: `out_trg_info` equals `evt_trg_info` of the same event, except that bit 14 is replaced by the forward flag.
- R11: `out_valid` is high exactly in the cycle after an accepted event with a non-zero mask, and it carries that event's index and flags.
- R12: While reset is high, and in the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rcv_mask | input | 16 | Receiver enable mask |
| cfg_mask_wr | input | 1 | One-cycle strobe: the mask was written |
| cfg_evt_per_rcv | input | 24 | Consecutive events per receiver (0 acts as 1) |
| cfg_hdr_factor | input | 16 | Header/trailer downscale factor (0 = every event) |
| evt_accept | input | 1 | One-cycle strobe for an accepted event |
| evt_trg_info | input | 16 | Trigger information of the event |
| out_valid | output | 1 | Dispatch strobe |
| out_rcv_idx | output | 4 | Selected receiver index |
| out_fwd_hdr | output | 1 | Forward headers/trailers for this event |
| out_trg_info | output | 16 | Trigger information with bit 14 set to the forward flag |

## Verification
Every result of this block comes from one register stage. The index, the forward flag, the information word and the valid strobe all belong to the edge that samples `evt_accept`.

The bench drives the strobe on a falling edge, lets one rising edge pass, and compares all four outputs at the next falling edge. It then drops the strobe and confirms that `out_valid` returns low.

The expected receiver and flag come from a bench-side walk of the mask and of the two counters.

// File: rtl/evb_sel_pkg.sv
package evb_sel_pkg;
    localparam int RCV_N     = 16;
    localparam int IDX_W     = $clog2(RCV_N);
    localparam int EPR_W     = 24;
    localparam int FAC_W     = 16;
    localparam int INFO_W    = 16;
    localparam int FWD_BIT   = 14;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic              fwd;
        logic [INFO_W-1:0] info;
    } dispatch_t;

    function automatic logic [INFO_W-1:0] stamp_info(input logic [INFO_W-1:0] info,
                                                     input logic fwd);
        logic [INFO_W-1:0] r;
        r = info;
        r[FWD_BIT] = fwd;
        return r;
    endfunction
endpackage

// File: rtl/evb_rcv_rotator.sv
module evb_rcv_rotator #(
    parameter int RCV_N = 16,
    parameter int EPR_W = 24,
    localparam int IDX_W = $clog2(RCV_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RCV_N-1:0] mask,
    input  logic             mask_wr,
    input  logic [EPR_W-1:0] evt_per_rcv,
    input  logic             take,
    output logic [IDX_W-1:0] sel_idx
);
    logic             restart_q;
    logic [IDX_W-1:0] cur_q;
    logic [EPR_W-1:0] cnt_q;
    logic             restart_eff;
    logic [EPR_W-1:0] cnt_eff;
    logic [EPR_W:0]   cnt_inc;
    logic [EPR_W:0]   limit;
    logic [IDX_W-1:0] low_idx;
    logic [IDX_W-1:0] nxt_idx;

    always_comb begin
        low_idx = '0;
        for (int i = RCV_N - 1; i >= 0; i--) begin
            if (mask[i]) low_idx = IDX_W'(i);
        end
    end

    always_comb begin
        nxt_idx = sel_idx;
        for (int d = RCV_N - 1; d >= 1; d--) begin
            if (mask[(int'(sel_idx) + d) % RCV_N])
                nxt_idx = IDX_W'((int'(sel_idx) + d) % RCV_N);
        end
    end

    assign restart_eff = restart_q | mask_wr;
    assign sel_idx     = restart_eff ? low_idx : cur_q;
    assign cnt_eff     = restart_eff ? '0 : cnt_q;
    assign cnt_inc     = {1'b0, cnt_eff} + 1'b1;
    assign limit       = (evt_per_rcv == '0) ? (EPR_W+1)'(1) : {1'b0, evt_per_rcv};

    always_ff @(posedge clk) begin
        if (rst) begin
            restart_q <= 1'b1;
            cur_q     <= '0;
            cnt_q     <= '0;
        end else if (take) begin
            restart_q <= 1'b0;
            if (cnt_inc >= limit) begin
                cnt_q <= '0;
                cur_q <= nxt_idx;
            end else begin
                cnt_q <= cnt_inc[EPR_W-1:0];
                cur_q <= sel_idx;
            end
        end else if (mask_wr) begin
            restart_q <= 1'b1;
            cnt_q     <= '0;
        end
    end

    // R2: the held count stays below the limit while the limit is unchanged
    a_r2_cnt_below_limit: assert property (@(posedge clk) disable iff (rst)
        $stable(evt_per_rcv) |-> ({1'b0, cnt_q} < limit));

    // R5: a mask write without an event restarts the rotation
    a_r5_wr_restarts: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && !take) |=> (restart_q && cnt_q == '0));
endmodule

// File: rtl/evb_hdr_thinner.sv
module evb_hdr_thinner #(
    parameter int FAC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FAC_W-1:0] factor,
    input  logic             take,
    output logic             fwd
);
    logic [FAC_W-1:0] hcnt_q;
    logic [FAC_W:0]   hinc;

    assign hinc = {1'b0, hcnt_q} + 1'b1;
    assign fwd  = (factor == '0) || (hcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt_q <= '0;
        end else if (take && factor != '0) begin
            if (hinc >= {1'b0, factor}) hcnt_q <= '0;
            else                        hcnt_q <= hinc[FAC_W-1:0];
        end
    end

    // R7: the header counter holds when no event is dispatched
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(hcnt_q));
endmodule

// File: rtl/evb_rr_selector.sv
module evb_rr_selector
    import evb_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RCV_N-1:0]  cfg_rcv_mask,
    input  logic              cfg_mask_wr,
    input  logic [EPR_W-1:0]  cfg_evt_per_rcv,
    input  logic [FAC_W-1:0]  cfg_hdr_factor,
    input  logic              evt_accept,
    input  logic [INFO_W-1:0] evt_trg_info,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_rcv_idx,
    output logic              out_fwd_hdr,
    output logic [INFO_W-1:0] out_trg_info
);
    logic             take;
    logic [IDX_W-1:0] sel_idx;
    logic             fwd;
    dispatch_t        nxt, q;

    assign take = evt_accept && (cfg_rcv_mask != '0);

    evb_rcv_rotator #(.RCV_N(RCV_N), .EPR_W(EPR_W)) u_rot (
        .clk(clk), .rst(rst), .mask(cfg_rcv_mask), .mask_wr(cfg_mask_wr),
        .evt_per_rcv(cfg_evt_per_rcv), .take(take), .sel_idx(sel_idx)
    );

    evb_hdr_thinner #(.FAC_W(FAC_W)) u_thin (
        .clk(clk), .rst(rst), .factor(cfg_hdr_factor), .take(take), .fwd(fwd)
    );

    always_comb begin
        nxt.valid = take;
        nxt.idx   = sel_idx;
        nxt.fwd   = fwd;
        nxt.info  = stamp_info(evt_trg_info, fwd);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign out_valid    = q.valid;
    assign out_rcv_idx  = q.idx;
    assign out_fwd_hdr  = q.fwd;
    assign out_trg_info = q.info;

    // R11: valid only after an accepted event
    a_r11_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(evt_accept));

    // R7: a zero mask gives no dispatch
    a_r7_zero_mask_silent: assert property (@(posedge clk) disable iff (rst)
        (evt_accept && cfg_rcv_mask == '0) |=> !out_valid);

    // R1: the index names an enabled receiver
    a_r1_idx_enabled: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (($past(cfg_rcv_mask) >> out_rcv_idx) & 16'd1) == 16'd1);

    // R8: a zero factor always forwards
    a_r8_zero_factor_fwd: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_hdr_factor) == '0) |-> out_fwd_hdr);

    // R10: the low information bits pass through unchanged
    a_r10_info_low: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_trg_info[13:0] == $past(evt_trg_info[13:0]));
endmodule

// File: tb/evb_rr_selector_tb.sv
module evb_rr_selector_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_rcv_mask;
    logic        cfg_mask_wr;
    logic [23:0] cfg_evt_per_rcv;
    logic [15:0] cfg_hdr_factor;
    logic        evt_accept;
    logic [15:0] evt_trg_info;
    logic        out_valid;
    logic [3:0]  out_rcv_idx;
    logic        out_fwd_hdr;
    logic [15:0] out_trg_info;

    int n_chk = 0;
    int n_bad = 0;

    bit      m_restart;
    int      m_cur, m_cnt, m_h;

    always #5 clk = ~clk;

    evb_rr_selector u_dut (
        .clk(clk), .rst(rst), .cfg_rcv_mask(cfg_rcv_mask), .cfg_mask_wr(cfg_mask_wr),
        .cfg_evt_per_rcv(cfg_evt_per_rcv), .cfg_hdr_factor(cfg_hdr_factor),
        .evt_accept(evt_accept), .evt_trg_info(evt_trg_info), .out_valid(out_valid),
        .out_rcv_idx(out_rcv_idx), .out_fwd_hdr(out_fwd_hdr), .out_trg_info(out_trg_info)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int after(input logic [15:0] m, input int c);
        for (int d = 1; d < 16; d++) if (m[(c + d) % 16]) return (c + d) % 16;
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; evt_accept = 1'b0; cfg_mask_wr = 1'b0;
        @(negedge clk);
        check("R12 valid", out_valid, 0);
        check("R12 idx", out_rcv_idx, 0);
        check("R12 fwd", out_fwd_hdr, 0);
        check("R12 info", out_trg_info, 0);
        rst = 1'b0;
        m_restart = 1'b1; m_cur = 0; m_cnt = 0; m_h = 0;
    endtask

    task automatic send(input logic [15:0] info, input bit mw);
        int  lim, sel, xfwd;
        bit  xv;
        @(negedge clk);
        evt_accept = 1'b1; evt_trg_info = info; cfg_mask_wr = mw;
        if (mw) begin m_restart = 1'b1; m_cnt = 0; end
        xv = (cfg_rcv_mask != 0);
        sel = m_restart ? lowest(cfg_rcv_mask) : m_cur;
        xfwd = (cfg_hdr_factor == 0 || m_h == 0) ? 1 : 0;
        if (xv) begin
            lim = (cfg_evt_per_rcv == 0) ? 1 : int'(cfg_evt_per_rcv);
            if (m_cnt + 1 >= lim) begin m_cnt = 0; m_cur = after(cfg_rcv_mask, sel); end
            else begin m_cnt = m_cnt + 1; m_cur = sel; end
            m_restart = 1'b0;
            if (cfg_hdr_factor != 0) m_h = (m_h + 1 >= int'(cfg_hdr_factor)) ? 0 : m_h + 1;
        end
        @(negedge clk);
        evt_accept = 1'b0; cfg_mask_wr = 1'b0;
        check("R11/R7 valid", out_valid, int'(xv));
        if (xv) begin
            check("R1/R2/R3/R4/R5/R6 idx", out_rcv_idx, sel);
            check("R8/R9 fwd", out_fwd_hdr, xfwd);
            check("R10 info", out_trg_info, (int'(info) & 'hBFFF) | (xfwd << 14));
        end
        @(negedge clk);
        check("R11 valid drops", out_valid, 0);
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] masks [5] = '{16'h8103, 16'h0001, 16'hFFFF, 16'h0240, 16'h8000};
        int eprs [4] = '{0, 1, 2, 3};
        int facs [4] = '{0, 1, 3, 5};
        rst = 1'b1; cfg_rcv_mask = '0; cfg_mask_wr = 1'b0; cfg_evt_per_rcv = '0;
        cfg_hdr_factor = '0; evt_accept = 1'b0; evt_trg_info = '0;
        // Sweep of masks, events per receiver and header factors (R1-R4, R6, R8-R10)
        foreach (masks[a]) foreach (eprs[b]) foreach (facs[c]) begin
            cfg_rcv_mask = masks[a];
            cfg_evt_per_rcv = 24'(eprs[b]);
            cfg_hdr_factor = 16'(facs[c]);
            do_reset();
            for (int e = 0; e < 14; e++) send(16'(e * 16'h1357), 1'b0);
        end
        // R5: restart by a mask write, alone and together with an event
        cfg_rcv_mask = 16'h8103; cfg_evt_per_rcv = 24'd2; cfg_hdr_factor = 16'd3;
        do_reset();
        for (int e = 0; e < 5; e++) send(16'h4321, 1'b0);
        @(negedge clk); cfg_rcv_mask = 16'h0A50; cfg_mask_wr = 1'b1;
        m_restart = 1'b1; m_cnt = 0;
        @(negedge clk); cfg_mask_wr = 1'b0;
        for (int e = 0; e < 6; e++) send(16'hFFFF, 1'b0);
        cfg_rcv_mask = 16'h0006;
        send(16'h0001, 1'b1);
        for (int e = 0; e < 5; e++) send(16'h0002, 1'b0);
        // R7: a zero mask gives no dispatch and advances no counter
        cfg_rcv_mask = 16'h0000;
        for (int e = 0; e < 3; e++) send(16'h0003, 1'b0);
        cfg_rcv_mask = 16'h0006;
        for (int e = 0; e < 4; e++) send(16'h0004, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule